// File: doc/BRIEF.md
# Timer Slave-Mode and Quadrature Controller

This block runs a free-wrapping up/down counter whose clocking comes from a configurable slave mode. With slave mode off, the counter advances once per clock while the counter-enable bit is set. In the two quadrature modes it steps on the edges of one channel and takes the direction from the level of the other channel. The two modes swap which channel gives the edges and which gives the direction. Channel inputs are expected to be filtered already. The block registers them once and compares them with the previous sample to find edges.

A 3-bit trigger-select field routes one of eight sources to a registered trigger-input output. The sources are four internal triggers, an either-edge detector on channel A, the channel A level, the channel B level and an external trigger. The trigger-select field is protected: a configuration write changes it only while the stored slave mode is off. A master-slave bit adds a fixed extra delay to the selected trigger, so that timers chained from this one stay aligned with their local start. A one-cycle trigger-output pulse marks each 0-to-1 transition of the counter-enable bit. Chained timers can use it as their start event.

All configuration fields are loaded together on a single write strobe. The count and the direction are registered outputs.

Top module: `tmr_slave_quad`

## Requirements
- R1: Reset sets the count to 0 and `dir_down` to 0 (up). It also clears `trig_out`, `trig_sel_o` and every configuration field.
- R2: In mode 000 the count rises by one on every clock edge at which the stored enable is 1, and holds while it is 0. `dir_down` keeps its previous value. After a write that sets the enable, the count first moves one cycle later, in the same cycle as the `trig_out` pulse.
- R3: In mode 001 each edge of channel B moves the count by one, with the direction taken from channel A. Edges on channel A leave the count unchanged.
- R4: In mode 010 each edge of channel A moves the count by one, with the direction taken from channel B. Edges on channel B leave the count unchanged.
- R5: The quadrature step is up when the edge channel rises while the direction channel is low, or falls while it is high; every other case steps down, and `dir_down` is set to 1 for down and 0 for up. The new count appears after the second rising clock edge following the input change. The enable bit has no effect in these modes.
- R6: The count wraps modulo 2^CNT_W in both directions: up from all-ones gives 0, and down from 0 gives all-ones.
- R7: Mode codes 011 through 111 behave exactly like mode 000. They count on the enable and hold `dir_down`, and channel edges have no effect.
- R8: Trigger-select codes map as follows: 000 to 011 select internal triggers 0 to 3, 100 selects the channel-A either-edge pulse, 101 the channel A level, 110 the channel B level and 111 the external trigger. With the master-slave bit clear, `trig_sel_o` follows the selected source after the second rising clock edge.
- R9: A write leaves the trigger-select field unchanged when the stored mode is not 000; the other fields of that write still take effect.
- R10: With the master-slave bit set, `trig_sel_o` lags the selected source by SYNC_DLY more cycles than with it clear.
- R11: `trig_out` is high for exactly one cycle after each 0-to-1 change of the stored enable, and it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Slave mode code |
| cfg_tsel | input | 3 | Trigger source select (written only while mode is 000) |
| cfg_msync | input | 1 | Master-slave alignment delay enable |
| cfg_cen | input | 1 | Counter enable |
| chan_a | input | 1 | Filtered channel A |
| chan_b | input | 1 | Filtered channel B |
| itrig | input | 4 | Internal trigger inputs 0 to 3 |
| etrig | input | 1 | Filtered external trigger |
| count | output | CNT_W | Counter value |
| dir_down | output | 1 | Direction, 1 = counting down |
| trig_sel_o | output | 1 | Selected, possibly delayed, trigger input |
| trig_out | output | 1 | One-cycle pulse on counter enable rising |

## Verification
The bench builds the block with CNT_W = 8 and SYNC_DLY = 2. The narrow counter lets a few hundred enabled cycles carry the count through an up-wrap, and a single down step from reset reaches the down-wrap. With a two-stage alignment delay, the master-slave lag can be told apart from the base latency of a single extra flop, because the two differ by two cycles.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam logic [2:0] SM_OFF  = 3'b000;
  localparam logic [2:0] SM_QB   = 3'b001;
  localparam logic [2:0] SM_QA   = 3'b010;
  localparam int         TSRC_N  = 8;
  localparam int         ITRIG_N = 4;

  function automatic logic is_quad(input logic [2:0] m);
    return (m == SM_QB) || (m == SM_QA);
  endfunction
endpackage

// File: rtl/tsq_in_sync.sv
module tsq_in_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] p
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
      p <= '0;
    end else begin
      q <= d;
      p <= q;
    end
  end
endmodule

// File: rtl/tsq_trig_sel.sv
module tsq_trig_sel
  import tsq_pkg::*;
#(
  parameter int SYNC_DLY = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         sel,
  input  logic               msync,
  input  logic [ITRIG_N-1:0] itrig,
  input  logic               etrig,
  input  logic               a_edge,
  input  logic               a_lvl,
  input  logic               b_lvl,
  output logic               trig_o
);
  localparam int PW = (SYNC_DLY < 1) ? 1 : SYNC_DLY;

  logic [ITRIG_N-1:0] itrig_q;
  logic               etrig_q;
  logic [TSRC_N-1:0]  src;
  logic               pick;
  logic [PW-1:0]      pipe;

  always_comb begin
    src  = {etrig_q, b_lvl, a_lvl, a_edge, itrig_q};
    pick = src[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      itrig_q <= '0;
      etrig_q <= 1'b0;
      pipe    <= '0;
      trig_o  <= 1'b0;
    end else begin
      itrig_q <= itrig;
      etrig_q <= etrig;
      pipe[0] <= pick;
      for (int i = 1; i < PW; i++) pipe[i] <= pipe[i-1];
      trig_o  <= msync ? pipe[PW-1] : pick;
    end
  end
endmodule

// File: rtl/tsq_counter.sv
module tsq_counter
  import tsq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic             cen,
  input  logic             a_q,
  input  logic             a_p,
  input  logic             b_q,
  input  logic             b_p,
  output logic [CNT_W-1:0] count,
  output logic             dir_down
);
  logic step_en;
  logic step_up;
  logic quad;

  always_comb begin
    quad    = is_quad(mode);
    step_en = 1'b0;
    step_up = 1'b1;
    unique case (mode)
      SM_QB: begin
        step_en = b_q ^ b_p;
        step_up = b_q ^ a_q;
      end
      SM_QA: begin
        step_en = a_q ^ a_p;
        step_up = a_q ^ b_q;
      end
      default: begin
        step_en = cen;
        step_up = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      dir_down <= 1'b0;
    end else if (step_en) begin
      count <= step_up ? count + 1'b1 : count - 1'b1;
      if (quad) dir_down <= ~step_up;
    end
  end
endmodule

// File: rtl/tmr_slave_quad.sv
module tmr_slave_quad
  import tsq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SYNC_DLY = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_mode,
  input  logic [2:0]         cfg_tsel,
  input  logic               cfg_msync,
  input  logic               cfg_cen,
  input  logic               chan_a,
  input  logic               chan_b,
  input  logic [ITRIG_N-1:0] itrig,
  input  logic               etrig,
  output logic [CNT_W-1:0]   count,
  output logic               dir_down,
  output logic               trig_sel_o,
  output logic               trig_out
);
  logic [2:0] mode_q;
  logic [2:0] tsel_q;
  logic       msync_q;
  logic       cen_q;
  logic       cen_prev;
  logic [1:0] ch_q;
  logic [1:0] ch_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= SM_OFF;
      tsel_q  <= '0;
      msync_q <= 1'b0;
      cen_q   <= 1'b0;
    end else if (cfg_we) begin
      mode_q  <= cfg_mode;
      msync_q <= cfg_msync;
      cen_q   <= cfg_cen;
      if (mode_q == SM_OFF) tsel_q <= cfg_tsel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cen_prev <= 1'b0;
      trig_out <= 1'b0;
    end else begin
      cen_prev <= cen_q;
      trig_out <= cen_q & ~cen_prev;
    end
  end

  tsq_in_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({chan_b, chan_a}),
    .q   (ch_q),
    .p   (ch_p)
  );

  tsq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_q),
    .cen      (cen_q),
    .a_q      (ch_q[0]),
    .a_p      (ch_p[0]),
    .b_q      (ch_q[1]),
    .b_p      (ch_p[1]),
    .count    (count),
    .dir_down (dir_down)
  );

  tsq_trig_sel #(.SYNC_DLY(SYNC_DLY)) u_tsel (
    .clk    (clk),
    .rst    (rst),
    .sel    (tsel_q),
    .msync  (msync_q),
    .itrig  (itrig),
    .etrig  (etrig),
    .a_edge (ch_q[0] ^ ch_p[0]),
    .a_lvl  (ch_q[0]),
    .b_lvl  (ch_q[1]),
    .trig_o (trig_sel_o)
  );
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       mode_q,
  input logic [2:0]       tsel_q,
  input logic             cen_q,
  input logic [CNT_W-1:0] count,
  input logic             dir_down,
  input logic             trig_out
);
  logic [CNT_W-1:0] prev_cnt;
  logic [CNT_W-1:0] diff;
  logic             live;
  logic             quad;

  always_ff @(posedge clk) begin
    prev_cnt <= count;
    live     <= !rst;
  end

  always_comb begin
    diff = count - prev_cnt;
    quad = (mode_q == 3'b001) || (mode_q == 3'b010);
  end

  // R11
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    trig_out |=> !trig_out);

  // R6 and R5: one step per cycle at most, wrapping allowed
  a_r6_unit_step: assert property (@(posedge clk) disable iff (rst)
    live |-> (diff == '0 || diff == {{(CNT_W-1){1'b0}}, 1'b1} || diff == '1));

  // R9
  a_r9_tsel_locked: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 3'b000) |=> $stable(tsel_q));

  // R2 and R7
  a_r2_dir_held: assert property (@(posedge clk) disable iff (rst)
    !quad |=> $stable(dir_down));

  // R2
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!quad && !cen_q) |=> $stable(count));
endmodule

bind tmr_slave_quad tsq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_q   (mode_q),
  .tsel_q   (tsel_q),
  .cen_q    (cen_q),
  .count    (count),
  .dir_down (dir_down),
  .trig_out (trig_out)
);

// File: tb/tb_tmr_slave_quad.sv
module tb_tmr_slave_quad;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam int TD = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_mode = '0;
  logic [2:0] cfg_tsel = '0;
  logic cfg_msync = 1'b0;
  logic cfg_cen = 1'b0;
  logic chan_a = 1'b0;
  logic chan_b = 1'b0;
  logic [3:0] itrig = '0;
  logic etrig = 1'b0;
  logic [TW-1:0] count;
  logic dir_down;
  logic trig_sel_o;
  logic trig_out;

  tmr_slave_quad #(.CNT_W(TW), .SYNC_DLY(TD)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_tsel(cfg_tsel), .cfg_msync(cfg_msync), .cfg_cen(cfg_cen),
    .chan_a(chan_a), .chan_b(chan_b), .itrig(itrig), .etrig(etrig),
    .count(count), .dir_down(dir_down), .trig_sel_o(trig_sel_o),
    .trig_out(trig_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // kinds: 0 count, 1 dir_down, 2 trig_out, 3 trig_sel_o
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sbq[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int cnt_e = 0;

  task automatic push(input int kind, input logic [31:0] v, input string req);
    item_t it;
    it.kind = kind;
    it.exp  = v;
    it.req  = req;
    sbq.push_back(it);
  endtask

  task automatic chk_cd(input int c, input bit d, input string req);
    push(0, c & ((1 << TW) - 1), req);
    push(1, d, req);
  endtask

  always begin
    @(negedge clk);
    #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.kind)
        0: act = 32'(count);
        1: act = 32'(dir_down);
        2: act = 32'(trig_out);
        default: act = 32'(trig_sel_o);
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%0h expected=%0h at %0t",
                 it.req, it.kind, act, it.exp, $time);
      end
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [2:0] m, input logic [2:0] ts,
                     input logic ms, input logic ce);
    cfg_we = 1'b1; cfg_mode = m; cfg_tsel = ts; cfg_msync = ms; cfg_cen = ce;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      5: chan_a = v;
      6: chan_b = v;
      7: etrig = v;
      default: itrig[s] = v;
    endcase
  endtask

  task automatic probe(input logic [2:0] ts);
    cfg(3'b000, ts, 1'b0, 1'b0);
    set_src(int'(ts), 1'b1);
    cyc(); push(3, 0, "R8");
    cyc(); push(3, 1, "R8");
    set_src(int'(ts), 1'b0);
    cyc(3); push(3, 0, "R8");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    // R1 reset state
    chk_cd(0, 0, "R1"); push(2, 0, "R1"); push(3, 0, "R1");
    cyc(3); chk_cd(0, 0, "R2");

    // R2 / R11 enable rising
    cfg(3'b000, 3'b000, 1'b0, 1'b1);
    chk_cd(0, 0, "R2"); push(2, 0, "R11");
    cyc(); chk_cd(1, 0, "R2"); push(2, 1, "R11");
    cyc(); chk_cd(2, 0, "R2"); push(2, 0, "R11");
    cyc(300); cnt_e = 302;
    chk_cd(cnt_e, 0, "R6");
    cfg(3'b000, 3'b000, 1'b0, 1'b0); cnt_e++;
    chk_cd(cnt_e, 0, "R2");
    cyc(4); chk_cd(cnt_e, 0, "R2");

    // R8 internal trigger 0, R10 alignment delay
    itrig[0] = 1'b1;
    cyc(); push(3, 0, "R8");
    cyc(); push(3, 1, "R8");
    itrig[0] = 1'b0;
    cyc(3);
    cfg(3'b000, 3'b000, 1'b1, 1'b0);
    cyc(2);
    itrig[0] = 1'b1;
    cyc(3); push(3, 0, "R10");
    cyc();  push(3, 1, "R10");
    itrig[0] = 1'b0;
    cyc(3); push(3, 1, "R10");
    cyc();  push(3, 0, "R10");
    cfg(3'b000, 3'b000, 1'b0, 1'b0);
    cyc(4);

    // R8 other sources
    probe(3'd1);
    probe(3'd3);
    probe(3'd5);
    probe(3'd6);
    probe(3'd7);
    cfg(3'b000, 3'b100, 1'b0, 1'b0);
    chan_a = 1'b1;
    cyc(); push(3, 0, "R8");
    cyc(); push(3, 1, "R8");
    cyc(); push(3, 0, "R8");
    chan_a = 1'b0;
    cyc(4);
    chk_cd(cnt_e, 0, "R2");

    // R3 mode 001, trigger select 6 accepted from mode 000
    cfg(3'b001, 3'b110, 1'b0, 1'b0);
    chan_b = 1'b1;
    cyc(2); cnt_e++; chk_cd(cnt_e, 0, "R3"); push(3, 1, "R8");
    // R9 ignored write of select 7, R5 enable has no effect
    cfg(3'b001, 3'b111, 1'b0, 1'b1);
    etrig = 1'b1; chan_b = 1'b0;
    cyc(2); cnt_e--; chk_cd(cnt_e, 1, "R5"); push(3, 0, "R9");
    cyc(3); chk_cd(cnt_e, 1, "R5"); push(3, 0, "R9");
    etrig = 1'b0;
    chan_a = 1'b1;
    cyc(3); chk_cd(cnt_e, 1, "R3");
    chan_b = 1'b1;
    cyc(2); cnt_e--; chk_cd(cnt_e, 1, "R5");
    chan_b = 1'b0;
    cyc(2); cnt_e++; chk_cd(cnt_e, 0, "R5");

    // R4 mode 010
    cfg(3'b010, 3'b000, 1'b0, 1'b0);
    chan_a = 1'b0;
    cyc(2); cnt_e--; chk_cd(cnt_e, 1, "R4");
    chan_b = 1'b1;
    cyc(3); chk_cd(cnt_e, 1, "R4");
    chan_a = 1'b1;
    cyc(2); cnt_e--; chk_cd(cnt_e, 1, "R4");
    chan_a = 1'b0;
    cyc(2); cnt_e++; chk_cd(cnt_e, 0, "R5");
    chan_a = 1'b1;
    cyc(2); cnt_e--; chk_cd(cnt_e, 1, "R4");

    // R7 codes above 010 act as disable
    cfg(3'b011, 3'b000, 1'b0, 1'b1);
    chk_cd(cnt_e, 1, "R7");
    cyc(); cnt_e++; chk_cd(cnt_e, 1, "R7"); push(2, 1, "R11");
    cyc(); cnt_e++; chk_cd(cnt_e, 1, "R7");
    cfg(3'b101, 3'b000, 1'b0, 1'b0); cnt_e++;
    chk_cd(cnt_e, 1, "R7");
    chan_a = 1'b0;
    cyc(3); chk_cd(cnt_e, 1, "R7");

    // R6 down wrap after reset
    chan_b = 1'b0;
    cyc(2);
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    chk_cd(0, 0, "R1");
    cfg(3'b010, 3'b000, 1'b0, 1'b0);
    chan_b = 1'b1;
    cyc(3); chk_cd(0, 0, "R4");
    chan_a = 1'b1;
    cyc(2); chk_cd(255, 1, "R6");

    cyc(2);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule